// File: doc/BRIEF.md
# Flexible Pulse-Per-Second Generator

This block drives a pulse output and a target-reached interrupt from a free-running system time. The time is a seconds count and a nanoseconds count, and the block compares the two together against a programmed target time. Software writes a 4-bit command together with a target time, a pulse width and a pulse interval. Width and interval are counted in clock ticks. The commands can start one pulse, start an endless pulse train, withdraw a pending start, end a running train at the target time or at once, and withdraw a pending end.

A written command is held in a command field. The controller acts on that command in the next clock, and the field then clears itself. The field accepts a new command only while it reads zero. A 2-bit target mode decides what happens when the target time is reached: the interrupt only, the pulse output only, or both. An enable input turns command interpretation on or off.

The controller has six states: IDLE, ARM_ONE (single pulse waiting for target), ARM_TRAIN (train waiting for target), ONE_HIGH (single pulse high), TRAIN_RUN (free-running train) and TRAIN_STOPPING (train running, stop pending at target). Its transitions are as follows:
- START_ONE goes from IDLE to ARM_ONE, and START_TRAIN goes from IDLE to ARM_TRAIN.
- The target match with output routing goes from ARM_ONE to ONE_HIGH and from ARM_TRAIN to TRAIN_RUN.
- CANCEL_START before the target goes from ARM_ONE or ARM_TRAIN back to IDLE.
- The end of the width goes from ONE_HIGH to IDLE.
- STOP_AT goes from TRAIN_RUN to TRAIN_STOPPING.
- CANCEL_STOP before the target goes from TRAIN_STOPPING back to TRAIN_RUN.
- The target match with output routing goes from TRAIN_STOPPING to IDLE.
- STOP_NOW goes from TRAIN_RUN or TRAIN_STOPPING to IDLE.

Top module: `pps_flex_gen`

## Requirements
- R1: Command codes are 0 none, 1 start single pulse, 2 start train, 3 cancel start, 4 stop train at target time, 5 stop train immediately, 6 cancel stop. A write of a code from 7 to 15 leaves the command field at 0 and has no effect.
- R2: A write of a valid code (cmd_wr high at a rising edge) shows in cmd_field after that edge. The command is acted on at the next edge, and cmd_field then reads 0. A write while cmd_field is non-zero is dropped.
- R3: A single pulse goes high in the first cycle after the edge at which system time is at or past the target. It stays high for pulse_width cycles and does not repeat.
- R4: A train rises first at the same point as a single pulse. Each pulse lasts pulse_width cycles, and successive rising edges are pulse_interval cycles apart (pulse_interval > pulse_width >= 1).
- R5: A started train keeps pulsing without limit until a stop command ends it.
- R6: A stop-immediately command ends a running train in the cycle after it is acted on, and the output then stays low.
- R7: A cancel-start command acted on before the target time is reached withdraws the pending single pulse or train, so no pulse follows.
- R8: A stop-at-time command lets the train keep pulsing until system time reaches the target. The output then stays low.
- R9: A cancel-stop command acted on before the stop target is reached keeps the train pulsing after that target has passed.
- R10: Target mode 0 raises only the interrupt on a target match. Mode 2 raises the interrupt and also starts or stops the output. Mode 3 only starts or stops the output. Mode 1 does neither. The interrupt is a one-cycle pulse, raised in the cycle after the edge at which time first reaches the target.
- R11: While flex_en is low, writes are not taken and cmd_field stays 0.
- R12: A command that does not match the current state has no effect, for example a stop with no train running. pps_out is low whenever no pulse is active, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick of width and interval counting |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_sec | input | SEC_W | System time, seconds part |
| sys_ns | input | NS_W | System time, nanoseconds part |
| flex_en | input | 1 | Enables command interpretation |
| cmd_wr | input | 1 | Command write strobe |
| cmd_in | input | 4 | Command code written with cmd_wr |
| tgt_mode | input | 2 | Target-match routing mode |
| tgt_sec | input | SEC_W | Target time, seconds part |
| tgt_ns | input | NS_W | Target time, nanoseconds part |
| pulse_width | input | CNT_W | High time of a pulse, in ticks |
| pulse_interval | input | CNT_W | Rise-to-rise spacing of the train, in ticks |
| cmd_field | output | 4 | Pending command; clears itself once acted on |
| pps_out | output | 1 | Pulse output |
| tgt_irq | output | 1 | One-cycle target-reached interrupt |

## Verification
The assertions check the command field on every cycle. A non-zero field must clear in the next cycle. Neither a reserved code nor a write with flex_en low may load the field. The interrupt must be a single-cycle pulse, and it must stay silent in output-only mode. Which cycle a pulse rises in, the width and interval spacing, the train running on without limit, and the effect of each cancel and stop relative to the target time depend on whole command sequences. Only the bench's directed scenarios show those, by timing rising edges against the target.

// File: rtl/pps_flex_pkg.sv
package pps_flex_pkg;

    typedef enum logic [3:0] {
        CMD_NONE         = 4'd0,
        CMD_START_ONE    = 4'd1,
        CMD_START_TRAIN  = 4'd2,
        CMD_CANCEL_START = 4'd3,
        CMD_STOP_AT      = 4'd4,
        CMD_STOP_NOW     = 4'd5,
        CMD_CANCEL_STOP  = 4'd6
    } pps_cmd_e;

    localparam logic [3:0] CMD_MAX_VALID = 4'd6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM_ONE,
        ST_ARM_TRAIN,
        ST_ONE_HIGH,
        ST_TRAIN_RUN,
        ST_TRAIN_STOPPING
    } pps_state_e;

endpackage

// File: rtl/pps_cmd_reg.sv
module pps_cmd_reg
    import pps_flex_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flex_en,
    input  logic       wr,
    input  logic [3:0] din,
    output logic [3:0] cmd_q
);
    logic take;

    // Accept only valid, non-zero codes while enabled and the field is empty
    assign take = wr && flex_en && (cmd_q == 4'd0) &&
                  (din != 4'd0) && (din <= CMD_MAX_VALID);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= 4'd0;
        else if (cmd_q != 4'd0)
            cmd_q <= 4'd0;          // consumed by the controller this cycle
        else if (take)
            cmd_q <= din;
    end
endmodule

// File: rtl/pps_time_cmp.sv
module pps_time_cmp #(
    parameter int SEC_W = 32,
    parameter int NS_W  = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] sys_sec,
    input  logic [NS_W-1:0]  sys_ns,
    input  logic [SEC_W-1:0] tgt_sec,
    input  logic [NS_W-1:0]  tgt_ns,
    output logic             reached,
    output logic             reached_rise
);
    localparam int TW = SEC_W + NS_W;

    logic [TW-1:0] now_t;
    logic [TW-1:0] tgt_t;
    logic          reached_q;

    assign now_t        = {sys_sec, sys_ns};
    assign tgt_t        = {tgt_sec, tgt_ns};
    assign reached      = (now_t >= tgt_t);
    assign reached_rise = reached && !reached_q;

    always_ff @(posedge clk) begin
        if (!rst_n) reached_q <= 1'b0;
        else        reached_q <= reached;
    end
endmodule

// File: rtl/pps_phase_ctr.sv
module pps_phase_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] width,
    input  logic [CNT_W-1:0] interval,
    output logic             in_width,
    output logic             width_last,
    output logic             period_last
);
    logic [CNT_W-1:0] cnt;

    assign in_width    = (cnt < width);
    assign width_last  = (cnt == width - 1'b1);
    assign period_last = (cnt == interval - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (run)
            cnt <= period_last ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/pps_flex_gen.sv
module pps_flex_gen
    import pps_flex_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int NS_W  = 30,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] sys_sec,
    input  logic [NS_W-1:0]  sys_ns,
    input  logic             flex_en,
    input  logic             cmd_wr,
    input  logic [3:0]       cmd_in,
    input  logic [1:0]       tgt_mode,
    input  logic [SEC_W-1:0] tgt_sec,
    input  logic [NS_W-1:0]  tgt_ns,
    input  logic [CNT_W-1:0] pulse_width,
    input  logic [CNT_W-1:0] pulse_interval,
    output logic [3:0]       cmd_field,
    output logic             pps_out,
    output logic             tgt_irq
);
    pps_state_e st, st_n;
    pps_cmd_e   cmd;
    logic       reached, reached_rise;
    logic       route_out, route_irq;
    logic       ctr_clear, ctr_run;
    logic       in_width, width_last, period_last;
    logic       irq_q;

    pps_cmd_reg u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .flex_en (flex_en),
        .wr      (cmd_wr),
        .din     (cmd_in),
        .cmd_q   (cmd_field)
    );

    assign cmd = pps_cmd_e'(cmd_field);

    pps_time_cmp #(.SEC_W(SEC_W), .NS_W(NS_W)) u_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .sys_sec      (sys_sec),
        .sys_ns       (sys_ns),
        .tgt_sec      (tgt_sec),
        .tgt_ns       (tgt_ns),
        .reached      (reached),
        .reached_rise (reached_rise)
    );

    pps_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (ctr_clear),
        .run         (ctr_run),
        .width       (pulse_width),
        .interval    (pulse_interval),
        .in_width    (in_width),
        .width_last  (width_last),
        .period_last (period_last)
    );

    // Target mode routing: 2'b00 irq only, 2'b10 both, 2'b11 output only, 2'b01 none
    assign route_out = tgt_mode[1];
    assign route_irq = (tgt_mode == 2'b00) || (tgt_mode == 2'b10);

    // Next-state logic
    always_comb begin
        st_n      = st;
        ctr_clear = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (cmd == CMD_START_ONE)        st_n = ST_ARM_ONE;
                else if (cmd == CMD_START_TRAIN) st_n = ST_ARM_TRAIN;
            end
            ST_ARM_ONE: begin
                if (cmd == CMD_CANCEL_START && !reached) begin
                    st_n = ST_IDLE;
                end else if (reached && route_out) begin
                    st_n      = ST_ONE_HIGH;
                    ctr_clear = 1'b1;
                end
            end
            ST_ARM_TRAIN: begin
                if (cmd == CMD_CANCEL_START && !reached) begin
                    st_n = ST_IDLE;
                end else if (reached && route_out) begin
                    st_n      = ST_TRAIN_RUN;
                    ctr_clear = 1'b1;
                end
            end
            ST_ONE_HIGH: begin
                if (width_last) st_n = ST_IDLE;
            end
            ST_TRAIN_RUN: begin
                if (cmd == CMD_STOP_NOW)     st_n = ST_IDLE;
                else if (cmd == CMD_STOP_AT) st_n = ST_TRAIN_STOPPING;
            end
            ST_TRAIN_STOPPING: begin
                if (cmd == CMD_STOP_NOW)                        st_n = ST_IDLE;
                else if (cmd == CMD_CANCEL_STOP && !reached)    st_n = ST_TRAIN_RUN;
                else if (reached && route_out)                  st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // Interrupt register
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= reached_rise && route_irq;
    end

    // Outputs
    always_comb begin
        ctr_run = 1'b0;
        pps_out = 1'b0;
        unique case (st)
            ST_ONE_HIGH: begin
                ctr_run = 1'b1;
                pps_out = 1'b1;
            end
            ST_TRAIN_RUN, ST_TRAIN_STOPPING: begin
                ctr_run = 1'b1;
                pps_out = in_width;
            end
            default: begin
                ctr_run = 1'b0;
                pps_out = 1'b0;
            end
        endcase
    end

    assign tgt_irq = irq_q;

endmodule

// File: rtl/pps_flex_gen_chk.sv
module pps_flex_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       flex_en,
    input logic       cmd_wr,
    input logic [3:0] cmd_in,
    input logic [1:0] tgt_mode,
    input logic [3:0] cmd_field,
    input logic       tgt_irq
);
    assert_cmd_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_field != 4'd0) |=> (cmd_field == 4'd0));

    assert_reserved_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_field == 4'd0 && cmd_wr && cmd_in > 4'd6) |=> (cmd_field == 4'd0));

    assert_disabled_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_field == 4'd0 && !flex_en) |=> (cmd_field == 4'd0));

    assert_irq_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_irq |=> !tgt_irq);

    assert_irq_silent_out_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_mode == 2'b11 && $past(tgt_mode) == 2'b11) |-> !tgt_irq);
endmodule

bind pps_flex_gen pps_flex_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flex_en   (flex_en),
    .cmd_wr    (cmd_wr),
    .cmd_in    (cmd_in),
    .tgt_mode  (tgt_mode),
    .cmd_field (cmd_field),
    .tgt_irq   (tgt_irq)
);

// File: tb/pps_flex_gen_test.sv
module pps_flex_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int SEC_W = 32;
    localparam int NS_W  = 30;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [31:0]      now;
    logic             flex_en = 1'b1;
    logic             cmd_wr = 1'b0;
    logic [3:0]       cmd_in = 4'd0;
    logic [1:0]       tgt_mode = 2'b10;
    logic [NS_W-1:0]  tgt_ns = '1;
    logic [CNT_W-1:0] pulse_width = 16'd4;
    logic [CNT_W-1:0] pulse_interval = 16'd10;
    logic [3:0]       cmd_field;
    logic             pps_out;
    logic             tgt_irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) now <= 32'd0;
        else        now <= now + 32'd1;
    end

    pps_flex_gen #(.SEC_W(SEC_W), .NS_W(NS_W), .CNT_W(CNT_W)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .sys_sec        ({SEC_W{1'b0}}),
        .sys_ns         (now[NS_W-1:0]),
        .flex_en        (flex_en),
        .cmd_wr         (cmd_wr),
        .cmd_in         (cmd_in),
        .tgt_mode       (tgt_mode),
        .tgt_sec        ({SEC_W{1'b0}}),
        .tgt_ns         (tgt_ns),
        .pulse_width    (pulse_width),
        .pulse_interval (pulse_interval),
        .cmd_field      (cmd_field),
        .pps_out        (pps_out),
        .tgt_irq        (tgt_irq)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic issue(input logic [3:0] c);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_in = c;
        @(negedge clk);
        cmd_wr = 1'b0;
        cmd_in = 4'd0;
    endtask

    task automatic set_tgt(input int ahead);
        tgt_ns = NS_W'(now + 32'(ahead));
    endtask

    task automatic find_rise(input int lim, output int at);
        at = -1;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (pps_out) begin
                at = int'(now) - 1;
                return;
            end
        end
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (pps_out && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_high_cycles(input int lim, output int n);
        n = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (pps_out) n++;
        end
    endtask

    task automatic t_reset;
        chk("R12 pps low after reset", int'(pps_out), 0);
        chk("R10 irq low after reset", int'(tgt_irq), 0);
        chk("R2 field zero after reset", int'(cmd_field), 0);
    endtask

    task automatic t_cmd_field;
        int n;
        tgt_mode = 2'b10;
        set_tgt(1000);
        issue(4'd1);
        chk("R2 field shows command", int'(cmd_field), 1);
        tick(1);
        chk("R2 field auto-clears", int'(cmd_field), 0);
        issue(4'd3);
        tick(1);
        issue(4'd9);
        chk("R1 reserved code not latched", int'(cmd_field), 0);
        flex_en = 1'b0;
        issue(4'd2);
        chk("R11 disabled write not latched", int'(cmd_field), 0);
        flex_en = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b1; cmd_in = 4'd2;
        @(negedge clk);
        cmd_in = 4'd5;
        chk("R2 first of back-to-back writes", int'(cmd_field), 2);
        @(negedge clk);
        cmd_wr = 1'b0; cmd_in = 4'd0;
        chk("R2 write while field busy dropped", int'(cmd_field), 0);
        issue(4'd3);
        count_high_cycles(20, n);
        chk("R12 no pulse after cancelled arms", n, 0);
    endtask

    task automatic t_single;
        int at, n;
        logic irq_seen;
        tgt_mode = 2'b10;
        pulse_width = 16'd5;
        set_tgt(20);
        issue(4'd1);
        find_rise(60, at);
        chk("R3 single pulse rises at target", at, int'(tgt_ns));
        irq_seen = tgt_irq;
        chk("R10 mode 2 irq with start", int'(irq_seen), 1);
        count_high(n);
        chk("R3 single pulse width", n, 5);
        count_high_cycles(30, n);
        chk("R3 single pulse not repeated", n, 0);
    endtask

    task automatic t_train;
        int a0, a1, n;
        tgt_mode = 2'b10;
        pulse_width = 16'd3;
        pulse_interval = 16'd8;
        set_tgt(15);
        issue(4'd2);
        find_rise(60, a0);
        chk("R4 train first rise at target", a0, int'(tgt_ns));
        for (int k = 0; k < 4; k++) begin
            count_high(n);
            chk("R4 train pulse width", n, 3);
            find_rise(30, a1);
            chk("R5 train keeps running, interval", a1 - a0, 8);
            a0 = a1;
        end
        issue(4'd5);
        tick(1);
        chk("R6 stop immediately drops output", int'(pps_out), 0);
        count_high_cycles(20, n);
        chk("R6 output stays low after stop", n, 0);
    endtask

    task automatic t_stop_at;
        int at, n;
        tgt_mode = 2'b10;
        set_tgt(10);
        issue(4'd2);
        find_rise(40, at);
        chk("R8 train started", int'(at >= 0), 1);
        set_tgt(50);
        issue(4'd4);
        find_rise(30, at);
        chk("R8 train runs until stop time", int'(at >= 0), 1);
        while (now < 32'(tgt_ns) + 32'd2) @(negedge clk);
        count_high_cycles(20, n);
        chk("R8 output low after stop time", n, 0);
    endtask

    task automatic t_cancel_stop;
        int at;
        tgt_mode = 2'b10;
        set_tgt(10);
        issue(4'd2);
        find_rise(40, at);
        set_tgt(40);
        issue(4'd4);
        issue(4'd6);
        while (now < 32'(tgt_ns) + 32'd5) @(negedge clk);
        find_rise(20, at);
        chk("R9 train still runs past stop time", int'(at >= 0), 1);
        issue(4'd5);
        tick(2);
    endtask

    task automatic t_cancel_start;
        int n;
        tgt_mode = 2'b10;
        set_tgt(30);
        issue(4'd1);
        issue(4'd3);
        count_high_cycles(60, n);
        chk("R7 cancelled start gives no pulse", n, 0);
        issue(4'd4);
        issue(4'd5);
        issue(4'd6);
        tick(1);
        chk("R12 stray stop commands clear field", int'(cmd_field), 0);
        count_high_cycles(20, n);
        chk("R12 stray commands leave output low", n, 0);
    endtask

    task automatic t_mode3;
        int n, irqs;
        tgt_mode = 2'b11;
        pulse_width = 16'd4;
        set_tgt(15);
        issue(4'd1);
        n = 0; irqs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pps_out) n++;
            if (tgt_irq) irqs++;
        end
        chk("R10 mode 3 drives output", n, 4);
        chk("R10 mode 3 raises no irq", irqs, 0);
    endtask

    task automatic t_mode0;
        int n, irqs;
        tgt_mode = 2'b00;
        set_tgt(15);
        issue(4'd1);
        n = 0; irqs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pps_out) n++;
            if (tgt_irq) irqs++;
        end
        chk("R10 mode 0 output untouched", n, 0);
        chk("R10 mode 0 single irq pulse", irqs, 1);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_cmd_field();
        t_single();
        t_train();
        t_stop_at();
        t_cancel_stop();
        t_cancel_start();
        t_mode3();
        t_mode0();
        report();
        $finish;
    end
endmodule